// File: doc/BRIEF.md
# Serial One-Time Memory Programming Sequencer

This block is the digital control for a one-time program memory while the memory is in programming mode. The programmer has no address pins to drive. An internal 10-bit address counter starts from zero when a clear code is applied. It then advances by counting pulses on an external step clock: every group of four pulses moves the address by one. A four-pin mode code chooses among address clear, write, read/verify and program inhibit. An 8-bit data path carries write data into the array or returns stored data, with an output-enable that releases the bus outside read/verify.

The external step clock and the mode pins are asynchronous to the block clock. Both are passed through two-flop synchronisers. A small state machine has four states: `ST_INHIBIT`, `ST_CLEAR`, `ST_WRITE` and `ST_READ`. Each cycle it moves from whatever state it is in to the state named by the synchronised mode code, so every state can reach every other state. Codes that are not listed lead to `ST_INHIBIT`. A write strobe to the array is raised for one cycle when mode bit 0 falls and the new code is the write code. This happens only on the transition into `ST_WRITE` from a code with bit 0 high. The array itself sits outside the block, behind a simple address / write-strobe / write-data / read-data port.

Top module: `otp_prog_seq`

## Requirements
- R1: Mode code {MD3,MD2,MD1,MD0} = 4'b0101 (clear) forces the array address to 0 and the step-pulse count to 0, and holds both there while the code is present, even when step pulses arrive.
- R2: When mode bit 0 falls and the new code is 4'b1110 (write), exactly one single-cycle `arr_we` pulse is issued, carrying `data_in` at the current address. `data_oe` stays low in write mode.
- R3: Mode code 4'b1100 (read/verify) sets `data_oe` high and drives `data_out` with `arr_rdata` for the current address. Entering read from a code with bit 0 high issues no write strobe.
- R4: Codes matching 4'b11x1 (inhibit) keep `data_oe` low and issue no write strobe.
- R5: Every code not listed in R1 to R4 behaves as inhibit: `data_oe` low, no strobe, and step counting continues.
- R6: Outside clear, the address advances by exactly one per four falling edges of `step_clk`, on the third falling edge of each group of four counted from the last clear.
- R7: The address wraps from 1023 to 0.
- R8: After reset the address is 0, `data_oe` is low and `arr_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_clk | input | 1 | External address step clock (asynchronous) |
| mode_pins | input | 4 | Mode code, bit i = MDi (asynchronous) |
| data_in | input | 8 | Data bus input side (write data) |
| data_out | output | 8 | Data bus output side (read data, 0 when released) |
| data_oe | output | 1 | Data bus output enable |
| arr_addr | output | 10 | Array address |
| arr_we | output | 1 | Array write strobe, one cycle |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data for `arr_addr` |

## Verification
The hardest case to reach is the address wrap. It requires 4096 counted falling edges with no clear in between. The stimulus applies a clear, then drives that many full step pulses in inhibit mode, and checks the address just before and just after the boundary. The increment falling on the third edge of a group is also checked directly: after a clear, two, three and four pulses are applied and the address is checked after each. Random mode codes, with write excluded, are mixed with random pulse bursts so that unlisted codes and clears land at arbitrary points inside a group of four.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
    typedef enum logic [1:0] {
        ST_INHIBIT = 2'd0,
        ST_CLEAR   = 2'd1,
        ST_WRITE   = 2'd2,
        ST_READ    = 2'd3
    } prog_state_t;

    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] CODE_CLEAR = 4'b0101;
    localparam logic [MODE_W-1:0] CODE_WRITE = 4'b1110;
    localparam logic [MODE_W-1:0] CODE_READ  = 4'b1100;

    function automatic prog_state_t decode_mode(input logic [MODE_W-1:0] code);
        prog_state_t s;
        if (code == CODE_CLEAR)      s = ST_CLEAR;
        else if (code == CODE_WRITE) s = ST_WRITE;
        else if (code == CODE_READ)  s = ST_READ;
        else                         s = ST_INHIBIT;
        return s;
    endfunction
endpackage

// File: rtl/otp_sync.sv
module otp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/otp_addr_counter.sv
module otp_addr_counter #(
    parameter int ADDR_W          = 10,
    parameter int PULSES_PER_STEP = 4,
    parameter int STEP_AT         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PC_W = (PULSES_PER_STEP > 1) ? $clog2(PULSES_PER_STEP) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSES_PER_STEP - 1);
    localparam logic [PC_W-1:0] PC_HIT  = PC_W'(STEP_AT);

    logic              step_q;
    logic              fall;
    logic [PC_W-1:0]   pcnt_q;
    logic [ADDR_W-1:0] addr_q;

    assign fall = step_q & ~step_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 1'b0;
        else        step_q <= step_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            addr_q <= '0;
        end else if (clr_i) begin
            pcnt_q <= '0;
            addr_q <= '0;
        end else if (fall) begin
            pcnt_q <= (pcnt_q == PC_LAST) ? '0 : pcnt_q + 1'b1;
            if (pcnt_q == PC_HIT) addr_q <= addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (addr_q == '0 && pcnt_q == '0)); // R1
    AST_STEP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !clr_i && pcnt_q == PC_HIT) |=> addr_q == $past(addr_q) + 1'b1); // R6
    AST_ADDR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> (addr_q == $past(addr_q) + 1'b1 || addr_q == '0)); // R7
endmodule

// File: rtl/otp_mode_fsm.sv
module otp_mode_fsm
    import otp_prog_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              oe_o,
    output logic              clr_o,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o
);
    prog_state_t       state_q, state_d;
    logic              md0_q;
    logic              md0_fall;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;

    assign state_d  = decode_mode(mode_i);
    assign md0_fall = md0_q & ~mode_i[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INHIBIT;
            md0_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            md0_q   <= mode_i[0];
        end
    end

    // write strobe and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            we_q <= md0_fall && (state_d == ST_WRITE);
            if (md0_fall && (state_d == ST_WRITE)) wdata_q <= data_i;
        end
    end

    // outputs per state
    always_comb begin
        oe_o  = 1'b0;
        clr_o = 1'b0;
        unique case (state_q)
            ST_INHIBIT: ;
            ST_CLEAR:   clr_o = 1'b1;
            ST_WRITE:   ;
            ST_READ:    oe_o  = 1'b1;
        endcase
    end

    assign we_o    = we_q;
    assign wdata_o = wdata_q;

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q); // R2
    AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (state_q == ST_WRITE && !oe_o)); // R2
    AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CODE_READ) |=> oe_o); // R3
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != CODE_READ) |=> !oe_o); // R4
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int ADDR_W          = 10,
    parameter int DATA_W          = 8,
    parameter int PULSES_PER_STEP = 4,
    parameter int STEP_AT         = 2,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_clk,
    input  logic [3:0]        mode_pins,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_we,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata
);
    logic              step_s;
    logic [MODE_W-1:0] mode_s;
    logic              clr;
    logic              oe;

    otp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_step_sync (
        .clk(clk), .rst_n(rst_n), .d(step_clk), .q(step_s)
    );
    otp_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .d(mode_pins), .q(mode_s)
    );

    otp_mode_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_s), .data_i(data_in),
        .oe_o(oe), .clr_o(clr), .we_o(arr_we), .wdata_o(arr_wdata)
    );

    otp_addr_counter #(
        .ADDR_W(ADDR_W), .PULSES_PER_STEP(PULSES_PER_STEP), .STEP_AT(STEP_AT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(step_s), .addr_o(arr_addr)
    );

    assign data_oe  = oe;
    assign data_out = oe ? arr_rdata : '0;

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0); // R4
endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_clk = 1'b0;
    logic [3:0] mode_pins = 4'b1111;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic [9:0] arr_addr;
    logic       arr_we;
    logic [7:0] arr_wdata;
    logic [7:0] arr_rdata;

    always #2.5 clk = ~clk;

    otp_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .mode_pins(mode_pins),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata)
    );

    // behavioural array
    logic [7:0] mem [1024];
    int         we_seen = 0;
    initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) if (arr_we) begin
        mem[arr_addr] <= arr_wdata;
        we_seen <= we_seen + 1;
    end

    // bench model
    logic [7:0] exp_mem [1024];
    int  exp_addr = 0, exp_pc = 0, exp_writes = 0;
    logic [3:0] cur_code = 4'b1111;
    int  n_tests = 0, n_fail = 0;
    bit  done = 0;

    function automatic bit is_clear(input logic [3:0] c); return c == 4'b0101; endfunction
    function automatic bit is_write(input logic [3:0] c); return c == 4'b1110; endfunction
    function automatic bit is_read (input logic [3:0] c); return c == 4'b1100; endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] c);
        if (cur_code[0] && !c[0] && is_write(c)) begin
            exp_writes++;
            exp_mem[exp_addr] = data_in;
        end
        mode_pins = c;
        cur_code  = c;
        if (is_clear(c)) begin exp_addr = 0; exp_pc = 0; end
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse();
        step_clk = 1'b1;
        repeat (8) @(negedge clk);
        step_clk = 1'b0;
        repeat (8) @(negedge clk);
        if (!is_clear(cur_code)) begin
            if (exp_pc == 2) exp_addr = (exp_addr + 1) % 1024;
            exp_pc = (exp_pc + 1) % 4;
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " addr"}, int'(arr_addr), exp_addr);
        check({req, " oe"}, int'(data_oe), int'(is_read(cur_code)));
        check({req, " writes"}, we_seen, exp_writes);
        if (is_read(cur_code)) check({req, " data"}, int'(data_out), int'(exp_mem[exp_addr]));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R8 reset state
        check("R8 addr", int'(arr_addr), 0);
        check("R8 oe", int'(data_oe), 0);
        check("R8 we", we_seen, 0);

        // R1 clear holds against pulses
        pulse(); pulse(); pulse();
        set_mode(4'b0101);
        check("R1 clear", int'(arr_addr), 0);
        pulse(); pulse(); pulse();
        check("R1 clear hold", int'(arr_addr), 0);

        // R6 increment on third fall
        set_mode(4'b1111);
        pulse(); pulse();
        check("R6 two falls", int'(arr_addr), 0);
        pulse();
        check("R6 third fall", int'(arr_addr), 1);
        pulse();
        check("R6 fourth fall", int'(arr_addr), 1);
        repeat (4) pulse();
        check("R6 next group", int'(arr_addr), 2);

        // R2 writes to addresses 0..5, R4 inhibit between
        set_mode(4'b0101);
        for (int i = 0; i < 6; i++) begin
            data_in = 8'($urandom);
            set_mode(4'b1111);
            check_outputs("R4");
            set_mode(4'b1110);
            check_outputs("R2");
            data_in = 8'($urandom);
            set_mode(4'b1101);
            check_outputs("R4");
            repeat (4) pulse();
        end

        // R3 read back, entering read from clear (bit0 falls, no strobe)
        set_mode(4'b0101);
        set_mode(4'b1100);
        for (int i = 0; i < 6; i++) begin
            check_outputs("R3");
            repeat (4) pulse();
        end

        // R5 unlisted codes
        begin
            logic [3:0] odd [5] = '{4'b0000, 4'b0110, 4'b1000, 4'b0011, 4'b0111};
            for (int i = 0; i < 5; i++) begin
                set_mode(odd[i]);
                check_outputs("R5");
                repeat (3) pulse();
                check_outputs("R5 count");
            end
        end

        // random mix, write code excluded
        for (int i = 0; i < 40; i++) begin
            logic [3:0] c;
            c = 4'($urandom);
            if (is_write(c)) c = 4'b1111;
            set_mode(c);
            repeat ($urandom % 7) pulse();
            check_outputs(is_clear(c) ? "R1 rand" : is_read(c) ? "R3 rand" : "R5 rand");
        end

        // R7 wrap
        set_mode(4'b0101);
        set_mode(4'b1111);
        repeat (4 * 1023) pulse();
        check("R7 top", int'(arr_addr), 1023);
        repeat (4) pulse();
        check("R7 wrap", int'(arr_addr), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule